// File: doc/BRIEF.md
# Atomic Cluster Firing Controller

This block schedules a small group of combinational operations as one indivisible node. The group has `N_IN` input channels and `N_OUT` output channels, and each channel uses a valid/ready handshake. A single controller replaces the per-operator handshake logic. It fires the whole group in one cycle, and only when two things hold: every input channel offers a token, and every output channel has room for a new one. On a firing it takes one token from every input and writes one result into every output holding register.

The valid bit at the boundary is the control token that travels beside each data word. It is a constant one whenever a word is present. On entry it is separated from the data and goes to the controller. The data goes to the datapath. On exit only the registered data is forwarded, and the output valid comes from the holding register's full flag.

The datapath is fixed and purely combinational, and it has two regions joined directly. The first region is a chain of adders that forms the sum `S` of all inputs modulo 2^`DW`. The second region rotates `S` to form each output. The intermediate value `S` passes between the two regions within the same firing, so the two regions behave as one region under this controller. The design target is a 100 MHz clock.

Top module: `cluster_fire_ctrl`

## Requirements
- R1: While `rst` (synchronous, active high) is asserted, and after its release until the first firing, every bit of `out_valid` is 0.
- R2: `in_ready` is asserted only when every bit of `in_valid` is 1 and, for every output j, either `out_valid[j]` is 0 or `out_ready[j]` is 1. When either condition fails, `in_ready` is all zeros.
- R3: A firing is all or nothing. Either every bit of `in_ready` is 1 or every bit is 0. In the cycle after a firing, every bit of `out_valid` is 1.
- R4: On a firing, output j (bits `j*DW +: DW` of `out_data`) takes the value `S` rotated left by `j mod DW` bits. `S` is the sum modulo 2^`DW` of all input words, where input i is bits `i*DW +: DW` of `in_data`.
- R5: While `out_valid[j]` is 1 and `out_ready[j]` is 0, output j stays valid and its data stays unchanged.
- R6: When `out_valid[j]` is 1, `out_ready[j]` is 1 and no firing occurs, `out_valid[j]` is 0 in the next cycle. Outputs drain independently of each other.
- R7: Tokens are paired by arrival order. The n-th result is computed from the n-th token of every input channel, even when the channels' tokens arrive at different times.
- R8: An output that is full and is accepted in the same cycle counts as having room. A firing then refills it in that cycle, so continuous traffic fires every cycle.
- R9: With `N_IN = 1` and `N_OUT = 1`, the block acts as a one-deep handshake register stage. `out_data` equals the accepted input word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_IN | Token present on each input channel |
| in_data | input | N_IN*DW | Input words, channel i at bits i*DW +: DW |
| in_ready | output | N_IN | Token taken on each input channel (all high only in a firing cycle) |
| out_valid | output | N_OUT | Output holding register full |
| out_data | output | N_OUT*DW | Held result words, channel j at bits j*DW +: DW |
| out_ready | input | N_OUT | Downstream accepts the held token |

## Verification
The bench builds two instances. The first uses three inputs, two outputs and 8-bit words. This configuration exercises uneven arrival across channels, a blocked output that holds back the other output, independent draining, and same-cycle refill. Its second output is rotated, so it also checks the second datapath region. The second instance uses one input and one output. It shows that the degenerate case acts as a plain register stage, covering both the half-full hold and back-to-back passing.

// File: rtl/cluster_fire_ctrl.sv
`timescale 1ns/1ps
module cluster_fire_ctrl #(
  parameter int N_IN  = 3,
  parameter int N_OUT = 2,
  parameter int DW    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_IN-1:0]       in_valid,
  input  logic [N_IN*DW-1:0]    in_data,
  output logic [N_IN-1:0]       in_ready,
  output logic [N_OUT-1:0]      out_valid,
  output logic [N_OUT*DW-1:0]   out_data,
  input  logic [N_OUT-1:0]      out_ready
);

  logic [N_OUT-1:0] full;
  logic [N_OUT-1:0] room;
  logic             fire;
  logic [DW-1:0]    mid;

  assign room     = ~full | out_ready;
  assign fire     = (&in_valid) & (&room);
  assign in_ready = {N_IN{fire}};

  always_comb begin
    mid = '0;
    for (int i = 0; i < N_IN; i++) mid = mid + in_data[i*DW +: DW];
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    localparam int SH = j % DW;
    logic [DW-1:0] res;
    logic [DW-1:0] hold_q;
    logic          full_q;

    if (SH == 0) begin : g_plain
      assign res = mid;
    end else begin : g_rot
      assign res = {mid[DW-1-SH:0], mid[DW-1:DW-SH]};
    end

    always_ff @(posedge clk) begin
      if (rst)               full_q <= 1'b0;
      else if (fire)         full_q <= 1'b1;
      else if (out_ready[j]) full_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst)       hold_q <= '0;
      else if (fire) hold_q <= res;
    end

    assign full[j]              = full_q;
    assign out_valid[j]         = full_q;
    assign out_data[j*DW +: DW] = hold_q;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (out_valid[j] && !out_ready[j]) |=> (out_valid[j] && $stable(out_data[j*DW +: DW])))
      else $error("held output changed"); // R5
    AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (out_valid[j] && out_ready[j] && !(|in_ready)) |=> !out_valid[j])
      else $error("accepted output not cleared"); // R6
  end

  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> (out_valid == '0))
    else $error("token present after reset"); // R1
  AST_FIRE_NEEDS_INPUTS: assert property (@(posedge clk) disable iff (rst)
    (|in_ready) |-> (&in_valid))
    else $error("fired without all inputs"); // R2
  AST_FIRE_NEEDS_ROOM: assert property (@(posedge clk) disable iff (rst)
    (|in_ready) |-> (&(~out_valid | out_ready)))
    else $error("fired into a blocked output"); // R2
  AST_FIRE_FILLS_ALL: assert property (@(posedge clk) disable iff (rst)
    (|in_ready) |=> (&out_valid))
    else $error("partial production"); // R3

endmodule

// File: tb/test_cluster_fire_ctrl.sv
`timescale 1ns/1ps
module test_cluster_fire_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [2:0]  a_iv = '0;
  logic [23:0] a_id = '0;
  logic [2:0]  a_ir;
  logic [1:0]  a_ov;
  logic [15:0] a_od;
  logic [1:0]  a_or = '0;

  logic        b_iv = 1'b0;
  logic [7:0]  b_id = '0;
  logic        b_ir;
  logic        b_ov;
  logic [7:0]  b_od;
  logic        b_or = 1'b0;

  int checks = 0;
  int errors = 0;

  cluster_fire_ctrl #(.N_IN(3), .N_OUT(2), .DW(8)) i_cluster_fire_ctrl (
    .clk(clk), .rst(rst), .in_valid(a_iv), .in_data(a_id), .in_ready(a_ir),
    .out_valid(a_ov), .out_data(a_od), .out_ready(a_or));

  cluster_fire_ctrl #(.N_IN(1), .N_OUT(1), .DW(8)) i_cluster_fire_ctrl_1x1 (
    .clk(clk), .rst(rst), .in_valid(b_iv), .in_data(b_id), .in_ready(b_ir),
    .out_valid(b_ov), .out_data(b_od), .out_ready(b_or));

  function automatic logic [7:0] model(input logic [23:0] d, input int j);
    logic [7:0]  s;
    logic [15:0] t;
    s = d[7:0] + d[15:8] + d[23:16];
    t = {s, s} << j;
    return t[15:8];
  endfunction

  function automatic logic [7:0] elem(input int c, input int n);
    return 8'(16*c + 7*n + 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 outputs empty in reset (3x2)", 32'(a_ov), 0);
    chk("R1 outputs empty in reset (1x1)", 32'(b_ov), 0);
    rst = 1'b0;
    a_iv = 3'b011; a_id = 24'h0A0B0C;
    #1 chk("R2 no ready with one input missing", 32'(a_ir), 0);
    @(negedge clk);
    #1 chk("R1 no token before first firing", 32'(a_ov), 0);
  endtask

  task automatic t_fire;
    logic [23:0] d;
    d = 24'h103520;
    @(negedge clk);
    a_iv = 3'b111; a_id = d;
    #1 chk("R2 ready with all inputs and room", 32'(a_ir), 32'h7);
    @(negedge clk);
    a_iv = '0;
    #1 chk("R3 every output produced", 32'(a_ov), 32'h3);
    chk("R4 output 0 is the sum", 32'(a_od[7:0]), 32'(model(d, 0)));
    chk("R4 output 1 is the rotated sum", 32'(a_od[15:8]), 32'(model(d, 1)));
  endtask

  task automatic t_hold_and_partial;
    logic [15:0] prev;
    logic [23:0] d2;
    prev = a_od;
    d2 = 24'hF1E2D3;
    @(negedge clk);
    a_or = 2'b00; a_iv = 3'b111; a_id = d2;
    #1 chk("R2 no ready while outputs blocked", 32'(a_ir), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1 chk("R5 outputs held valid", 32'(a_ov), 32'h3);
      chk("R5 output data held", 32'(a_od), 32'(prev));
    end
    a_or = 2'b01;
    #1 chk("R2 no ready while output 1 blocked", 32'(a_ir), 0);
    @(negedge clk);
    a_or = 2'b00;
    #1 chk("R6 output 0 drained alone", 32'(a_ov), 32'h2);
    chk("R5 output 1 data kept", 32'(a_od[15:8]), 32'(prev[15:8]));
    chk("R2 still no ready with output 1 full", 32'(a_ir), 0);
    a_or = 2'b10;
    #1 chk("R8 fires while output 1 is being taken", 32'(a_ir), 32'h7);
    @(negedge clk);
    a_or = 2'b00; a_iv = '0;
    #1 chk("R3 both outputs refilled", 32'(a_ov), 32'h3);
    chk("R4 refilled output 0", 32'(a_od[7:0]), 32'(model(d2, 0)));
    chk("R4 refilled output 1", 32'(a_od[15:8]), 32'(model(d2, 1)));
    a_or = 2'b11;
    @(negedge clk);
    #1 chk("R6 both outputs drained", 32'(a_ov), 0);
  endtask

  task automatic t_stream;
    logic [23:0] d;
    a_or = 2'b11;
    for (int k = 0; k < 5; k++) begin
      d = {8'(k*3+2), 8'(k*11+5), 8'(k*29+9)};
      a_iv = 3'b111; a_id = d;
      #1 chk("R8 fires every cycle when drained", 32'(a_ir), 32'h7);
      @(negedge clk);
      #1 chk("R8 outputs valid in stream", 32'(a_ov), 32'h3);
      chk("R4 stream output 0", 32'(a_od[7:0]), 32'(model(d, 0)));
      chk("R4 stream output 1", 32'(a_od[15:8]), 32'(model(d, 1)));
    end
    a_iv = '0;
    @(negedge clk);
  endtask

  task automatic t_order;
    int ptr[3];
    int nf;
    int kk;
    bit pend;
    logic [23:0] exp_d;
    nf = 0; pend = 0; kk = 0;
    for (int c = 0; c < 3; c++) ptr[c] = 0;
    a_or = 2'b11;
    for (int cyc = 0; cyc < 80 && nf < 4; cyc++) begin
      @(negedge clk);
      if (pend) begin
        exp_d = {elem(2, kk), elem(1, kk), elem(0, kk)};
        chk("R7 paired result output 0", 32'(a_od[7:0]), 32'(model(exp_d, 0)));
        chk("R7 paired result output 1", 32'(a_od[15:8]), 32'(model(exp_d, 1)));
        pend = 0;
      end
      for (int c = 0; c < 3; c++) begin
        a_iv[c] = (ptr[c] < 4) && (cyc >= ptr[c]*(c+1) + c);
        a_id[c*8 +: 8] = elem(c, ptr[c]);
      end
      #1;
      if (|a_ir) begin
        pend = 1; kk = nf; nf++;
      end
      for (int c = 0; c < 3; c++) if (a_ir[c] && a_iv[c]) ptr[c]++;
    end
    @(negedge clk);
    if (pend) begin
      exp_d = {elem(2, kk), elem(1, kk), elem(0, kk)};
      chk("R7 paired result output 0", 32'(a_od[7:0]), 32'(model(exp_d, 0)));
      chk("R7 paired result output 1", 32'(a_od[15:8]), 32'(model(exp_d, 1)));
    end
    a_iv = '0;
    chk("R7 four firings from skewed arrivals", 32'(nf), 4);
  endtask

  task automatic t_single;
    @(negedge clk);
    b_or = 1'b0; b_iv = 1'b1; b_id = 8'hA5;
    #1 chk("R9 stage accepts when empty", 32'(b_ir), 1);
    @(negedge clk);
    b_id = 8'h3C;
    #1 chk("R9 stage holds word", 32'(b_od), 32'hA5);
    chk("R9 stage valid", 32'(b_ov), 1);
    chk("R9 stage full refuses", 32'(b_ir), 0);
    @(negedge clk);
    b_or = 1'b1;
    #1 chk("R9 stage refills on accept", 32'(b_ir), 1);
    @(negedge clk);
    b_iv = 1'b0;
    #1 chk("R9 stage passes next word", 32'(b_od), 32'h3C);
    chk("R9 stage still valid", 32'(b_ov), 1);
    @(negedge clk);
    #1 chk("R9 stage empties", 32'(b_ov), 0);
  endtask

  initial begin
    t_reset();
    t_fire();
    t_hold_and_partial();
    t_stream();
    t_order();
    t_single();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule